// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital half of a current limiter for a three-phase bridge. It chops by holding the off-time constant, so there is no switching period. The bridge gets its current while the low-side switches conduct. When a limit comparator reports that the sensed current has passed the setpoint, the block removes every low-side enable for a programmed number of clock cycles. It then hands them back at once. Nothing else ends an on-interval, so its length depends only on how quickly the current climbs back to the limit.

A second, independent guard handles gross overcurrent. When the sense level goes above an upper threshold, a latch inhibits all low-side drives. The latch releases only after the level has dropped below a lower threshold, which gives two-threshold hysteresis. The commutation logic supplies per-phase low-side and high-side requests. The block gates only the low-side set. The high-side requests pass through untouched. The comparators, the sense amplifier and the setpoint converter are outside the block. Their results arrive as synchronous bits.

Top module: `offtime_chopper`

## Requirements
- R1: A synchronous reset clears the off-time timer and the overcurrent latch. In the cycle after reset, with `drive_en` high, `lo_gate` equals `lo_req` bit for bit.
- R2: A `limit_trip` sampled while the timer is idle forces `lo_gate` to all zeros. This starts with the clock edge that samples the trip and lasts exactly `off_cycles` cycles.
- R3: A `limit_trip` sampled while an off-time is running is ignored. It neither extends nor restarts the off-time.
- R4: When an off-time expires, the low-side enables return in the very next cycle. If `limit_trip` is still high, a new off-time starts at the following edge, so a held trip gives `off_cycles` blocked cycles followed by one enabled cycle, repeating.
- R5: An `off_cycles` value of zero is treated as one cycle.
- R6: `sense_over_hi` sampled high inhibits all low-side enables from that edge on.
- R7: The inhibit is held for as long as `sense_under_lo` stays low. It is released at the first edge that samples `sense_under_lo` high with `sense_over_hi` low.
- R8: When `sense_over_hi` and `sense_under_lo` are both high, the inhibit is set.
- R9: `drive_en` low forces `lo_gate` to zero in the same cycle, whatever the timer and latch are doing.
- R10: `hi_gate` always equals `hi_req`. The chopper, the latch and `drive_en` have no effect on it.
- R11: `off_cycles` is captured when an off-time starts. Changing it during a running off-time does not change that off-time's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| off_cycles | input | CNT_W | Off-time length in clock cycles |
| limit_trip | input | 1 | Limit comparator: current above setpoint |
| sense_over_hi | input | 1 | Sense level above the upper threshold |
| sense_under_lo | input | 1 | Sense level below the lower threshold |
| drive_en | input | 1 | External permission for low-side drive |
| lo_req | input | PHASES | Low-side requests from commutation |
| hi_req | input | PHASES | High-side requests from commutation |
| lo_gate | output | PHASES | Gated low-side enables |
| hi_gate | output | PHASES | High-side enables (pass-through) |

## Verification
A limit trip and an upper-threshold crossing can be sampled on the same edge. The vector table drives both bits together. It then drops the sense level below the lower threshold while the off-time is still running. The low-side enables must stay off until the timer has expired as well, which shows that the two blockers act independently and are ANDed. The other collision is a trip that arrives on the last cycle of an off-time. It is provoked by holding the trip high, and it is judged by the one enabled cycle that must appear before the new off-time.

// File: rtl/chop_pkg.sv
package chop_pkg;

   // comparator bundle seen by the chopper core
   typedef struct packed {
      logic trip;
      logic over_hi;
      logic under_lo;
   } sense_t;

   // latch update decision
   typedef enum logic [1:0] {
      OCP_HOLD  = 2'd0,
      OCP_SET   = 2'd1,
      OCP_CLEAR = 2'd2
   } ocp_act_t;

endpackage

// File: rtl/chop_offtimer.sv
module chop_offtimer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trip_i,
   input  logic [CNT_W-1:0] off_len_i,
   output logic             busy_o
);
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ZERO = '0;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("chop_offtimer: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_len;

   // a zero length would never block; clamp to one cycle
   assign load_len = (off_len_i == ZERO) ? ONE : off_len_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= ZERO;
      end else if (cnt_q != ZERO) begin
         cnt_q <= cnt_q - ONE;          // no retrigger while running
      end else if (trip_i) begin
         cnt_q <= load_len;
      end
   end

   assign busy_o = (cnt_q != ZERO);

   // R3: a running off-time only counts down
   p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
      (cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

   // R4: last count always leaves an idle cycle
   p_gap_after_expiry_r4: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == ONE) |=> !busy_o);

   // R2 / R5: an idle trip always blocks the next cycle
   p_start_on_trip_r2: assert property (@(posedge clk) disable iff (rst)
      (!busy_o && trip_i) |=> busy_o);

endmodule

// File: rtl/chop_ocp_latch.sv
module chop_ocp_latch
   import chop_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  sense_t sense_i,
   output logic   inhibit_o
);
   ocp_act_t act;

   always_comb begin
      if (sense_i.over_hi)       act = OCP_SET;    // upper threshold wins
      else if (sense_i.under_lo) act = OCP_CLEAR;
      else                       act = OCP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         inhibit_o <= 1'b0;
      end else begin
         case (act)
            OCP_SET:   inhibit_o <= 1'b1;
            OCP_CLEAR: inhibit_o <= 1'b0;
            default:   inhibit_o <= inhibit_o;
         endcase
      end
   end

   // R6 / R8: crossing the upper threshold always inhibits
   p_set_on_high_r6: assert property (@(posedge clk) disable iff (rst)
      sense_i.over_hi |=> inhibit_o);

   // R7: hysteresis band keeps the inhibit
   p_hold_in_band_r7: assert property (@(posedge clk) disable iff (rst)
      (inhibit_o && !sense_i.under_lo) |=> inhibit_o);

   // R7: release only below the lower threshold
   p_release_r7: assert property (@(posedge clk) disable iff (rst)
      (sense_i.under_lo && !sense_i.over_hi) |=> !inhibit_o);

endmodule

// File: rtl/chop_gate_mask.sv
module chop_gate_mask #(
   parameter int PHASES   = 3,
   parameter bit REG_MASK = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy_i,
   input  logic              inhibit_i,
   input  logic              enable_i,
   input  logic [PHASES-1:0] lo_req_i,
   output logic [PHASES-1:0] lo_gate_o
);
   generate
      if (PHASES < 1) begin : g_bad_phases
         $error("chop_gate_mask: PHASES must be at least 1");
      end
   endgenerate

   logic allow;

   generate
      if (REG_MASK) begin : g_reg
         logic allow_q;
         always_ff @(posedge clk) begin
            if (rst) allow_q <= 1'b0;
            else     allow_q <= !busy_i && !inhibit_i && enable_i;
         end
         assign allow = allow_q;
      end else begin : g_comb
         assign allow = !busy_i && !inhibit_i && enable_i;

         // R9: external disable takes the low side off at once
         p_enable_blocks_r9: assert property (@(posedge clk) disable iff (rst)
            !enable_i |-> (lo_gate_o == '0));
      end
   endgenerate

   generate
      for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
         assign lo_gate_o[ph] = lo_req_i[ph] & allow;
      end
   endgenerate

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
   import chop_pkg::*;
#(
   parameter int PHASES   = 3,
   parameter int CNT_W    = 12,
   parameter bit REG_MASK = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  off_cycles,
   input  logic              limit_trip,
   input  logic              sense_over_hi,
   input  logic              sense_under_lo,
   input  logic              drive_en,
   input  logic [PHASES-1:0] lo_req,
   input  logic [PHASES-1:0] hi_req,
   output logic [PHASES-1:0] lo_gate,
   output logic [PHASES-1:0] hi_gate
);
   sense_t sense;
   logic   off_busy;
   logic   ocp_inh;

   assign sense = '{trip: limit_trip, over_hi: sense_over_hi, under_lo: sense_under_lo};

   chop_offtimer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .trip_i   (sense.trip),
      .off_len_i(off_cycles),
      .busy_o   (off_busy)
   );

   chop_ocp_latch u_ocp (
      .clk      (clk),
      .rst      (rst),
      .sense_i  (sense),
      .inhibit_o(ocp_inh)
   );

   chop_gate_mask #(.PHASES(PHASES), .REG_MASK(REG_MASK)) u_mask (
      .clk      (clk),
      .rst      (rst),
      .busy_i   (off_busy),
      .inhibit_i(ocp_inh),
      .enable_i (drive_en),
      .lo_req_i (lo_req),
      .lo_gate_o(lo_gate)
   );

   // high side is never chopped
   assign hi_gate = hi_req;

   // R2 / R6: either blocker empties the low side (combinational variant)
   generate
      if (!REG_MASK) begin : g_chk
         p_blockers_clear_low_r2: assert property (@(posedge clk) disable iff (rst)
            (off_busy || ocp_inh) |-> (lo_gate == '0));
      end
   endgenerate

endmodule

// File: tb/offtime_chopper_bench.sv
module offtime_chopper_bench;
   localparam int PHASES = 3;
   localparam int CNT_W  = 12;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [CNT_W-1:0]  off_cycles = 12'd3;
   logic              limit_trip = 1'b0;
   logic              sense_over_hi = 1'b0;
   logic              sense_under_lo = 1'b0;
   logic              drive_en = 1'b1;
   logic [PHASES-1:0] lo_req = 3'b111;
   logic [PHASES-1:0] hi_req = 3'b000;
   logic [PHASES-1:0] lo_gate;
   logic [PHASES-1:0] hi_gate;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;   // 250 MHz

   offtime_chopper #(.PHASES(PHASES), .CNT_W(CNT_W)) u_offtime_chopper (
      .clk, .rst, .off_cycles, .limit_trip, .sense_over_hi, .sense_under_lo,
      .drive_en, .lo_req, .hi_req, .lo_gate, .hi_gate
   );

   task automatic chk(input string req, input logic [PHASES-1:0] act,
                      input logic [PHASES-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // fields: trip, over_hi, under_lo, enable, expected allow ; off_cycles = 3
   localparam logic [4:0] VEC [19] = '{
      5'b0_0_0_1_1,  //  0 idle, R1
      5'b1_0_0_1_0,  //  1 trip starts off-time, R2
      5'b1_0_0_1_0,  //  2 trip ignored, R3
      5'b0_0_0_1_0,  //  3
      5'b1_0_0_1_1,  //  4 expiry gives one enabled cycle, R4
      5'b1_0_0_1_0,  //  5 held trip restarts, R4
      5'b0_0_0_1_0,  //  6
      5'b0_0_0_1_0,  //  7
      5'b0_0_0_1_1,  //  8 exactly three blocked, R2
      5'b0_0_0_0_0,  //  9 external disable, R9
      5'b0_1_0_1_0,  // 10 upper threshold, R6
      5'b0_0_0_1_0,  // 11 in band: held, R7
      5'b0_0_1_1_1,  // 12 below lower: released, R7
      5'b0_1_1_1_0,  // 13 both thresholds: set wins, R8
      5'b0_0_1_1_1,  // 14 released
      5'b1_1_0_1_0,  // 15 trip and overcurrent same edge
      5'b0_0_1_1_0,  // 16 latch released, timer still runs, R2
      5'b0_0_0_1_0,  // 17
      5'b0_0_0_1_1   // 18
   };

   initial begin : watchdog
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset state", lo_gate, 3'b111);

      for (int i = 0; i < 19; i++) begin
         limit_trip     = VEC[i][4];
         sense_over_hi  = VEC[i][3];
         sense_under_lo = VEC[i][2];
         drive_en       = VEC[i][1];
         hi_req         = 3'(i);
         @(negedge clk);
         chk($sformatf("R2-table row %0d lo_gate", i), lo_gate, VEC[i][0] ? 3'b111 : 3'b000);
         chk("R10 high side pass", hi_gate, 3'(i));
      end
      limit_trip = 1'b0; sense_over_hi = 1'b0; sense_under_lo = 1'b0; drive_en = 1'b1;

      // R1 partial request mask passes through when nothing blocks
      lo_req = 3'b101;
      @(negedge clk);
      chk("R1 partial request", lo_gate, 3'b101);
      lo_req = 3'b111;

      // R5 zero length behaves as one cycle
      off_cycles = '0; limit_trip = 1'b1;
      @(negedge clk);
      chk("R5 zero length blocks", lo_gate, 3'b000);
      limit_trip = 1'b0;
      @(negedge clk);
      chk("R5 zero length ends", lo_gate, 3'b111);

      // R11 length captured at start
      off_cycles = 12'd2; limit_trip = 1'b1;
      @(negedge clk);
      chk("R11 start", lo_gate, 3'b000);
      limit_trip = 1'b0; off_cycles = 12'd5;
      @(negedge clk);
      chk("R11 second cycle", lo_gate, 3'b000);
      @(negedge clk);
      chk("R11 ends after two", lo_gate, 3'b111);

      // R1 reset mid off-time and with latch set
      off_cycles = 12'd4; limit_trip = 1'b1; sense_over_hi = 1'b1;
      @(negedge clk);
      chk("R1 blocked before reset", lo_gate, 3'b000);
      limit_trip = 1'b0; sense_over_hi = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset clears timer and latch", lo_gate, 3'b111);
      @(negedge clk);
      chk("R1 stays clear after reset", lo_gate, 3'b111);

      // R7 long hold in band
      sense_over_hi = 1'b1;
      @(negedge clk);
      sense_over_hi = 1'b0;
      repeat (6) @(negedge clk);
      chk("R7 long hold", lo_gate, 3'b000);
      sense_under_lo = 1'b1;
      @(negedge clk);
      chk("R7 release", lo_gate, 3'b111);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule